// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to 32 interrupt sources and drives one active-low interrupt line to a processor. Each source is configured through its own control word, which selects one of four trigger kinds (low level, high level, falling edge, rising edge) and a 3-bit priority. A source takes part in arbitration only while it is pending and enabled. The enable set is changed through separate enable and disable command words, each written as a bit vector. Software can also force a source pending or clear it, using another pair of command words.

The processor services an interrupt in three steps. When the line goes low, it reads the vector word. That read returns the winning source number multiplied by four and opens a service window. While the window is open the line stays high. The processor then writes the end-of-service word, which closes the window. If anything eligible is still pending at that point, the line drops again.

The register port is plain and single-cycle. An access is one cycle with `reg_en` high. Writes take effect at that clock edge. Read data comes back one cycle later, marked by `reg_rvalid`. The port has no back-pressure: every access is accepted in the cycle it is presented. Accesses whose two low address bits are not zero are ignored.

Top module: `vic_core`

## Requirements
- R1: After reset, every source is disabled, no service window is open, `irq_n` is 1, and every control word reads 0x40 (high level, priority 0).
- R2: In the control word of source i, at byte offset 4*i, bits [7:6] select the trigger (0 low level, 1 high level, 2 falling edge, 3 rising edge) and bits [2:0] hold the priority. A write sets both fields, and a read returns them in the same positions with all other bits 0.
- R3: A level source is pending while its input is at the active level. Its pending state follows the input with one cycle of delay.
- R4: An edge source latches the selected transition as pending and holds it until that source is acknowledged or cleared. A new edge in the same cycle as the clear wins.
- R5: Writing 1s to 0x120 enables the matching sources, and writing 1s to 0x124 disables them. Bits written as 0 leave their sources unchanged. The enable set reads back at 0x114, with 1 meaning enabled.
- R6: Among pending, enabled sources, the highest priority value wins, and ties go to the lowest source number.
- R7: A read of 0x10C returns the winner's number times four, opens the service window, records the winner (readable at 0x110), and clears its latched edge and any forced pending state. If nothing is eligible, the read returns 0 and opens no window.
- R8: Any write to 0x130 closes the service window. `irq_n` is 0 exactly when an eligible source exists and no window is open.
- R9: Writing 1s to 0x128 forces the matching sources pending. Writing 1s to 0x12C removes forced and latched-edge pending from the matching sources.
- R10: Read-only views: raw inputs at 0x100, pending (any kind) at 0x104, pending and enabled at 0x108, and line asserted (bit 0 = not `irq_n`) at 0x118. Unmapped words read 0.
- R11: `irq_n` reflects the state of the previous cycle through one register, and read data appears exactly one cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Interrupt source inputs, synchronous to clk |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | AW | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A source input change becomes pending at the next clock edge, and `irq_n` responds one edge after that, so a line reaction is due two edges after the input moves. A vector read opens the window at its own edge, so `irq_n` returns high on the second edge after the read. Read data is due on the first negative edge after the read's clock edge. The bench drives inputs on negative edges and advances a behavioural model on positive edges. It compares `irq_n`, `reg_rvalid` and `reg_rdata` against that model on every negative edge. Directed reads and line checks are placed at least those two edges after their stimulus.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    TRIG_LVL_LO   = 2'd0,
    TRIG_LVL_HI   = 2'd1,
    TRIG_EDGE_FALL = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_e;

  localparam int WORD_W = 7;
  localparam logic [WORD_W-1:0] W_RAW   = 7'h40;
  localparam logic [WORD_W-1:0] W_PEND  = 7'h41;
  localparam logic [WORD_W-1:0] W_STAT  = 7'h42;
  localparam logic [WORD_W-1:0] W_VEC   = 7'h43;
  localparam logic [WORD_W-1:0] W_CUR   = 7'h44;
  localparam logic [WORD_W-1:0] W_ENRD  = 7'h45;
  localparam logic [WORD_W-1:0] W_OUT   = 7'h46;
  localparam logic [WORD_W-1:0] W_ENSET = 7'h48;
  localparam logic [WORD_W-1:0] W_ENCLR = 7'h49;
  localparam logic [WORD_W-1:0] W_FSET  = 7'h4A;
  localparam logic [WORD_W-1:0] W_FCLR  = 7'h4B;
  localparam logic [WORD_W-1:0] W_EOS   = 7'h4C;
endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell
  import vic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src,
  input  logic [1:0] trig,
  input  logic       force_set,
  input  logic       force_clr,
  input  logic       ack_clr,
  output logic       pend
);
  logic prev_q, hold_q, frc_q;
  logic is_edge, lvl_act, edge_hit, drop;

  always_comb begin
    is_edge  = trig[1];
    lvl_act  = (trig_e'(trig) == TRIG_LVL_HI) ? src : ~src;
    edge_hit = (trig_e'(trig) == TRIG_EDGE_RISE) ? (src & ~prev_q)
                                                 : (~src & prev_q);
    drop     = force_clr | ack_clr;
    pend     = hold_q | frc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hold_q <= 1'b0;
      frc_q  <= 1'b0;
    end else begin
      prev_q <= src;
      if (is_edge) hold_q <= (hold_q & ~drop) | edge_hit;
      else         hold_q <= lvl_act;
      frc_q <= (frc_q & ~drop) | force_set;
    end
  end

  AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge && hold_q && !drop && $stable(trig)) |=> hold_q); // R4
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          cand,
  input  logic [NSRC-1:0][PW-1:0]  prio,
  output logic                     any,
  output logic [IDW-1:0]           win_id
);
  logic [PW-1:0] best_p;

  always_comb begin
    any    = 1'b0;
    win_id = '0;
    best_p = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!any || prio[i] > best_p)) begin
        any    = 1'b1;
        win_id = IDW'(i);
        best_p = prio[i];
      end
    end
  end

  AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> cand[win_id]); // R6
  AST_NONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !any |-> (cand == '0)); // R6
endmodule

// File: rtl/vic_core.sv
module vic_core
  import vic_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  parameter int AW   = 9,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            reg_en,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            reg_rvalid,
  output logic            irq_n
);
  logic [NSRC-1:0][1:0]    trig_q;
  logic [NSRC-1:0][PW-1:0] prio_q;
  logic [NSRC-1:0]         en_q, pend, cand;
  logic [NSRC-1:0]         fset_v, fclr_v, ack_v;
  logic                    in_svc_q, irq_q, any;
  logic [IDW-1:0]          cur_q, win_id;
  logic [WORD_W-1:0]       word;
  logic                    aligned, rd, wr, scr_hit, ack_fire, eos_wr;
  logic [31:0]             rdata_d;

  always_comb begin
    word     = reg_addr[AW-1:2];
    aligned  = (reg_addr[1:0] == 2'b00);
    rd       = reg_en & ~reg_we & aligned;
    wr       = reg_en &  reg_we & aligned;
    scr_hit  = (int'(word) < NSRC);
    ack_fire = rd && (word == W_VEC) && any;
    eos_wr   = wr && (word == W_EOS);
    fset_v   = (wr && word == W_FSET) ? reg_wdata[NSRC-1:0] : '0;
    fclr_v   = (wr && word == W_FCLR) ? reg_wdata[NSRC-1:0] : '0;
    ack_v    = ack_fire ? (NSRC'(1) << win_id) : '0;
    cand     = pend & en_q;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    vic_src_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .src       (src_in[g]),
      .trig      (trig_q[g]),
      .force_set (fset_v[g]),
      .force_clr (fclr_v[g]),
      .ack_clr   (ack_v[g]),
      .pend      (pend[g])
    );
  end

  vic_prio_pick #(.NSRC(NSRC), .PW(PW)) u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .cand   (cand),
    .prio   (prio_q),
    .any    (any),
    .win_id (win_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        trig_q[i] <= TRIG_LVL_HI;
        prio_q[i] <= '0;
      end
      en_q <= '0;
    end else if (wr) begin
      if (scr_hit) begin
        trig_q[word[IDW-1:0]] <= reg_wdata[7:6];
        prio_q[word[IDW-1:0]] <= reg_wdata[PW-1:0];
      end
      if (word == W_ENSET) en_q <= en_q | reg_wdata[NSRC-1:0];
      if (word == W_ENCLR) en_q <= en_q & ~reg_wdata[NSRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_svc_q <= 1'b0;
      cur_q    <= '0;
      irq_q    <= 1'b1;
    end else begin
      irq_q <= ~(any & ~in_svc_q);
      if (ack_fire) begin
        in_svc_q <= 1'b1;
        cur_q    <= win_id;
      end else if (eos_wr) begin
        in_svc_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_d = '0;
    if (scr_hit) begin
      rdata_d[7:6]    = trig_q[word[IDW-1:0]];
      rdata_d[PW-1:0] = prio_q[word[IDW-1:0]];
    end else begin
      case (word)
        W_RAW:  rdata_d = 32'(src_in);
        W_PEND: rdata_d = 32'(pend);
        W_STAT: rdata_d = 32'(cand);
        W_VEC:  rdata_d = any ? (32'(win_id) << 2) : 32'd0;
        W_CUR:  rdata_d = 32'(cur_q);
        W_ENRD: rdata_d = 32'(en_q);
        W_OUT:  rdata_d = {31'd0, ~irq_q};
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= rd;
      if (rd) reg_rdata <= rdata_d;
    end
  end

  assign irq_n = irq_q;

  AST_QUIET_IN_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc_q |=> irq_n); // R8
  AST_ACK_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (in_svc_q && cur_q == $past(win_id))); // R7
  AST_EOS_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (eos_wr && !ack_fire) |=> !in_svc_q); // R8
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> reg_rvalid); // R11
  AST_EN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && word == W_ENSET) |=> ((en_q & $past(reg_wdata[NSRC-1:0])) == $past(reg_wdata[NSRC-1:0]))); // R5
endmodule

// File: tb/vic_core_tb_top.sv
module vic_core_tb_top;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src_in = '0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid, irq_n;

  int vectors = 0, fails = 0;
  bit live = 0;
  logic [31:0] got;

  always #2.5 clk = ~clk;

  vic_core dut_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_en(reg_en),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .irq_n(irq_n)
  );

  // behavioural reference model
  int  m_trig[N], m_prio[N];
  bit  m_en[N], m_hold[N], m_frc[N], m_prev[N];
  bit  m_svc, m_irqn, m_rv;
  int  m_cur;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_trig[i] = 1; m_prio[i] = 0; m_en[i] = 0;
        m_hold[i] = 0; m_frc[i] = 0; m_prev[i] = 0;
      end
      m_svc = 0; m_irqn = 1; m_rv = 0; m_cur = 0; m_rd = 0;
    end else begin
      int best, w, ack;
      bit nirq, al;
      logic [31:0] pv, sv, ev;
      best = -1; ack = -1; pv = 0; sv = 0; ev = 0;
      for (int i = 0; i < N; i++) begin
        pv[i] = m_hold[i] | m_frc[i];
        ev[i] = m_en[i];
        sv[i] = pv[i] & m_en[i];
        if (sv[i] && (best < 0 || m_prio[i] > m_prio[best])) best = i;
      end
      nirq = !((best >= 0) && !m_svc);
      w  = int'(reg_addr) / 4;
      al = (reg_addr % 4) == 0;
      m_rv = reg_en && !reg_we && al;
      if (m_rv) begin
        if (w < N) m_rd = (m_trig[w] << 6) | m_prio[w];
        else case (w)
          'h40: m_rd = src_in;
          'h41: m_rd = pv;
          'h42: m_rd = sv;
          'h43: m_rd = (best >= 0) ? best * 4 : 0;
          'h44: m_rd = m_cur;
          'h45: m_rd = ev;
          'h46: m_rd = !m_irqn;
          default: m_rd = 0;
        endcase
        if (w == 'h43 && best >= 0) begin
          ack = best; m_svc = 1; m_cur = best;
        end
      end
      for (int i = 0; i < N; i++) begin
        bit drop, det;
        drop = (ack == i);
        if (reg_en && reg_we && al) begin
          if (w == i) begin m_trig[i] = reg_wdata[7:6]; m_prio[i] = reg_wdata[2:0]; end
          if (w == 'h48 && reg_wdata[i]) m_en[i] = 1;
          if (w == 'h49 && reg_wdata[i]) m_en[i] = 0;
          if (w == 'h4B && reg_wdata[i]) drop = 1;
        end
        if (m_trig[i] >= 2) begin
          det = (m_trig[i] == 3) ? (src_in[i] && !m_prev[i]) : (!src_in[i] && m_prev[i]);
          m_hold[i] = (m_hold[i] && !drop) || det;
        end else m_hold[i] = (m_trig[i] == 1) ? src_in[i] : !src_in[i];
        m_frc[i] = (m_frc[i] && !drop) || (reg_en && reg_we && al && w == 'h4A && reg_wdata[i]);
        m_prev[i] = src_in[i];
      end
      if (reg_en && reg_we && al && w == 'h4C && ack < 0) m_svc = 0;
      m_irqn = nirq;
    end
  end

  always @(negedge clk) if (live) begin
    vectors++;
    if (irq_n !== m_irqn) begin
      fails++; $display("FAIL R11 irq_n got %0b exp %0b", irq_n, m_irqn);
    end
    if (reg_rvalid !== m_rv || (m_rv && reg_rdata !== m_rd)) begin
      fails++;
      $display("FAIL R11 read got v%0b %h exp v%0b %h", reg_rvalid, reg_rdata, m_rv, m_rd);
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++; $display("FAIL %s got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_en = 1; reg_we = 1; reg_addr = 9'(a); reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input int a);
    reg_en = 1; reg_we = 0; reg_addr = 9'(a);
    @(negedge clk);
    reg_en = 0;
    got = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    live = 1;
    idle(1);
    chk(irq_n, 1, "R1 line idle");
    rd('h114); chk(got, 0, "R1 all disabled");
    rd(5*4);   chk(got, 32'h40, "R1 control reset");
    wr(3*4, 32'hC5);
    rd(3*4);   chk(got, 32'hC5, "R2 control readback");
    // level high source 4
    wr(4*4, 32'h42);
    wr('h120, 32'h10);
    src_in[4] = 1; idle(3);
    chk(irq_n, 0, "R3 level high raises line");
    rd('h10C); chk(got, 16, "R7 vector of source 4");
    idle(2);
    chk(irq_n, 1, "R7 line released in service");
    rd('h110); chk(got, 4, "R7 current source");
    src_in[4] = 0;
    wr('h130, 0); idle(3);
    chk(irq_n, 1, "R8 nothing left after end of service");
    rd('h104); chk(got, 0, "R3 level follows input");
    // low level source 6, left disabled
    wr(6*4, 32'h01); idle(2);
    rd('h104); chk(got, 32'h40, "R3 low level pending");
    src_in[6] = 1; idle(2);
    rd('h104); chk(got, 0, "R3 low level released");
    // rising edge source 3 (prio 5)
    wr('h120, 32'h08);
    src_in[3] = 1; idle(1); src_in[3] = 0; idle(3);
    rd('h104); chk(got, 32'h08, "R4 edge latched");
    chk(irq_n, 0, "R4 edge raises line");
    rd('h10C); chk(got, 12, "R7 vector of source 3");
    idle(1);
    rd('h104); chk(got, 0, "R4 acknowledge clears edge");
    wr('h130, 0);
    // falling edge source 7
    wr(7*4, 32'h81);
    src_in[7] = 1; idle(2); src_in[7] = 0; idle(3);
    rd('h104); chk(got, 32'h80, "R4 falling edge latched");
    wr('h12C, 32'h80); idle(1);
    rd('h104); chk(got, 0, "R9 clear command");
    // arbitration
    wr(8*4, 32'h43); wr(9*4, 32'h46); wr(10*4, 32'h46);
    wr('h120, 32'h700);
    src_in[8] = 1; src_in[9] = 1; src_in[10] = 1; idle(3);
    rd('h10C); chk(got, 36, "R6 highest priority, lowest index");
    wr('h130, 0); idle(2);
    chk(irq_n, 0, "R8 line again after end of service");
    rd('h10C); chk(got, 36, "R6 same winner");
    wr('h130, 0);
    wr('h124, 32'h200);
    rd('h114); chk(got, 32'h518, "R5 enable set readback");
    rd('h10C); chk(got, 40, "R5 masked source skipped");
    wr('h130, 0);
    src_in[8] = 0; src_in[9] = 0; src_in[10] = 0; idle(3);
    chk(irq_n, 1, "R8 idle when nothing eligible");
    rd('h10C); chk(got, 0, "R7 empty vector read");
    idle(2);
    // forced source 12
    wr('h120, 32'h1000);
    wr('h128, 32'h1000); idle(3);
    chk(irq_n, 0, "R9 forced source raises line");
    rd('h10C); chk(got, 48, "R9 vector of forced source");
    idle(1);
    rd('h104); chk(got, 0, "R9 acknowledge drops force");
    wr('h130, 0);
    // status views
    src_in[20] = 1; idle(2);
    rd('h100); chk(got, 32'h0010_0040, "R10 raw view");
    rd('h104); chk(got, 32'h0010_0000, "R10 pending view");
    rd('h108); chk(got, 0, "R10 enabled pending view");
    rd('h118); chk(got, 0, "R10 output view");
    rd('h0FC); chk(got, 0, "R10 unmapped word");
    idle(4);
    live = 0;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule